// File: doc/BRIEF.md
# Picture Decode Scheduler with Timestamp Gating

This block decides what happens to the next coded picture each time the display sync level changes. The outcomes are: start decoding it, hold it, drop it because its timestamp is already late, or skip it on a host trick-play command. A 20-bit local time counter runs from a 27 MHz enable at one step per 300 enables, which gives 90 kHz. The host loads that counter. Each picture's decode timestamp is taken from a small FIFO, which also carries an 8-bit picture tag. The decision compares the timestamp against the local time through a signed tolerance window.

After a picture starts, the scheduler waits one sync duration: one sync change for a field picture, two for a frame picture. If decoding ends inside that duration, the change that closes the duration starts the next check. If it does not end in time, the block enters an overrun state. It then starts the next check the moment decoding completes, without waiting for a sync change. A host command is latched as pending and takes effect at the next check launch, or at a sync change while a picture is held.

Top module: `picsync_sched`

## Requirements
- R1: After reset, `state_o` is 0 (waiting for sync), all pulse outputs are 0 and `stc_o` is 0. State codes: 0 wait, 1 check, 2 hold, 3 busy, 4 overrun.
- R2: A `stc_ld` pulse sets `stc_o` to `stc_ld_val` on the next cycle and clears the prescaler. After that, `stc_o` increments (modulo 2^20) on the 300th `tick_27m` cycle, and does not change without a tick or a load.
- R3: Let d = (timestamp − `stc_o`) mod 2^20, read as signed. The timestamp is in the window when backward < d < forward. The tolerances reset to forward 0x00E10 and backward 0xFFABA (−1350). `tol_wr` with `tol_sel`=0 writes forward and with `tol_sel`=1 writes backward.
- R4: If d ≤ backward, the picture is discarded (`discard_o` pulse) when `low_delay`=1 or `pic_is_b`=1. Otherwise it is decoded as in-window.
- R5: If d ≥ forward, the picture is held in state 2 until d falls inside the window, then `dec_start_o` pulses.
- R6: With `ts_chk_en`=0 or an empty timestamp FIFO, the picture is treated as in-window.
- R7: `buf_ready`=0, or `pic_top` differing from the `disp_sync` level, holds the picture in state 2 until the condition clears.
- R8: Each start, skip or discard pops one timestamp in push order. `pic_tag_o` then shows that entry's tag, or 0 if the FIFO was empty. The FIFO holds 4 entries, and a push while full is ignored.
- R9: A started picture occupies 1 sync change (`pic_frame`=0) or 2 (`pic_frame`=1). If `dec_done` arrives before the last one, that last sync change launches the next check.
- R10: If the duration closes without `dec_done`, the state becomes 4. The next `dec_done` then launches a check without any sync change.
- R11: Commands (`cmd_code`) are applied at a check launch or at a sync change while holding. The codes are: 5 pause (hold), 1/2/3 play, 4 decode one picture then pause, 6 skip B pictures with a `skip_o` pulse, 0 flush the FIFO and play, 7 no change.
- R12: `dec_start_o`, `skip_o` and `discard_o` are single-cycle pulses, and at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_27m | input | 1 | 27 MHz rate enable |
| stc_ld | input | 1 | Load local time counter |
| stc_ld_val | input | 20 | Value to load |
| tol_wr | input | 1 | Tolerance write strobe |
| tol_sel | input | 1 | 0 forward, 1 backward tolerance |
| tol_val | input | 20 | Tolerance value (two's complement) |
| ts_push | input | 1 | Push a timestamp |
| ts_val | input | 20 | Timestamp value |
| ts_tag | input | 8 | Picture tag stored with it |
| cmd_wr | input | 1 | Latch a pending command |
| cmd_code | input | 3 | Command code |
| disp_sync | input | 1 | Display sync level (1 = top field) |
| buf_ready | input | 1 | One whole picture is buffered |
| pic_top | input | 1 | Picture needs a top-field sync level |
| pic_frame | input | 1 | Frame picture (two-change duration) |
| pic_is_b | input | 1 | Picture is bidirectionally predicted |
| low_delay | input | 1 | Low-delay mode |
| ts_chk_en | input | 1 | Timestamp checking enable |
| dec_done | input | 1 | Decoder finished the picture |
| dec_start_o | output | 1 | Start decoding pulse |
| skip_o | output | 1 | Command skip pulse |
| discard_o | output | 1 | Late-timestamp discard pulse |
| pic_tag_o | output | 8 | Tag of the consumed timestamp |
| state_o | output | 3 | Scheduler state code |
| stc_o | output | 20 | Local time counter |

## Verification
A vector table walks timestamp offsets just inside and on each edge of the default window, far early, far late, and one offset whose plain unsigned reading would contradict its signed one. This separates off-by-one window bounds from sign errors. Each late vector is repeated with the B-picture and low-delay flags varied, to separate discard from decode. Directed sequences cover the following and tell a launch taken at the wrong moment from a correct one:
- field versus frame durations;
- done-before-sync versus overrun;
- pause, step and skip commands;
- FIFO flush and overflow;
- counter wraparound.

// File: rtl/picsync_pkg.sv
// Shared types and constants for the picture decode scheduler.
// Assumes command codes are fixed by the host-side decoder of cmd_code.
package picsync_pkg;
    localparam int STC_W = 20;
    localparam int TAG_W = 8;

    typedef enum logic [2:0] {
        ST_WAIT  = 3'd0,
        ST_CHECK = 3'd1,
        ST_HOLD  = 3'd2,
        ST_BUSY  = 3'd3,
        ST_OVR   = 3'd4
    } sched_st_e;

    typedef enum logic [1:0] {
        RM_PLAY  = 2'd0,
        RM_PAUSE = 2'd1,
        RM_STEP  = 2'd2,
        RM_FAST  = 2'd3
    } run_mode_e;

    localparam logic [2:0] CMD_RESET = 3'd0;
    localparam logic [2:0] CMD_PLAY  = 3'd1;
    localparam logic [2:0] CMD_STEP  = 3'd4;
    localparam logic [2:0] CMD_PAUSE = 3'd5;
    localparam logic [2:0] CMD_FAST  = 3'd6;
    localparam logic [2:0] CMD_NONE  = 3'd7;
endpackage

// File: rtl/picsync_stc.sv
// Local time counter: loadable, steps once every DIV cycles of the rate enable.
// Assumes a load outranks a tick in the same cycle and restarts the prescaler.
module picsync_stc #(
    parameter int TW  = 20,
    parameter int DIV = 300
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] stc
);
    localparam int DW = $clog2(DIV);
    localparam logic [DW-1:0] PRE_LAST = DW'(DIV - 1);

    logic [DW-1:0] pre_q;

    // Prescale the rate enable and advance the counter on the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            stc   <= '0;
        end else if (load) begin
            pre_q <= '0;
            stc   <= load_val;
        end else if (tick) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                stc   <= stc + 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/picsync_ts_fifo.sv
// Timestamp FIFO with a picture tag per entry.
// Assumes DEPTH is a power of two of at least 2; push when full and pop when empty are dropped.
module picsync_ts_fifo #(
    parameter int TW    = 20,
    parameter int NW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [TW-1:0] push_ts,
    input  logic [NW-1:0] push_tag,
    input  logic          pop,
    output logic [TW-1:0] head_ts,
    output logic [NW-1:0] head_tag,
    output logic          empty
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CNT_FULL = (AW+1)'(DEPTH);

    logic [TW-1:0] ts_mem  [DEPTH];
    logic [NW-1:0] tag_mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [AW:0]   cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign do_push = push && (cnt_q != CNT_FULL);
    assign do_pop  = pop && !empty;
    assign head_ts  = ts_mem[rd_q];
    assign head_tag = tag_mem[rd_q];

    // Store an accepted entry at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            ts_mem[wr_q]  <= push_ts;
            tag_mem[wr_q] <= push_tag;
        end
    end

    // Move pointers and occupancy; flush empties the queue.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/picsync_window.sv
// Signed tolerance window between a timestamp and the local time.
// Assumes modulo-2^TW arithmetic, so a counter wrap never flips the verdict.
module picsync_window #(
    parameter int TW = 20
) (
    input  logic [TW-1:0] dts,
    input  logic [TW-1:0] stc,
    input  logic [TW-1:0] jit_fwd,
    input  logic [TW-1:0] jit_bwd,
    output logic          late,
    output logic          early
);
    logic [TW-1:0] diff;

    // Classify the signed distance against both bounds.
    always_comb begin
        diff  = dts - stc;
        late  = $signed(diff) <= $signed(jit_bwd);
        early = $signed(diff) >= $signed(jit_fwd);
    end
endmodule

// File: rtl/picsync_sched.sv
// Picture decode scheduler: once per display-sync period decides start, hold,
// discard or skip, and tracks the sync duration and overrun of the decode.
// Assumes dec_done is a one-cycle pulse from the decoder and disp_sync is synchronous.
module picsync_sched
    import picsync_pkg::*;
#(
    parameter int          TW         = 20,
    parameter int          TAGW       = 8,
    parameter int          FIFO_DEPTH = 4,
    parameter int          STC_DIV    = 300,
    parameter logic [19:0] JF_RST     = 20'h00E10,
    parameter logic [19:0] JB_RST     = 20'hFFABA
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_27m,
    input  logic            stc_ld,
    input  logic [TW-1:0]   stc_ld_val,
    input  logic            tol_wr,
    input  logic            tol_sel,
    input  logic [TW-1:0]   tol_val,
    input  logic            ts_push,
    input  logic [TW-1:0]   ts_val,
    input  logic [TAGW-1:0] ts_tag,
    input  logic            cmd_wr,
    input  logic [2:0]      cmd_code,
    input  logic            disp_sync,
    input  logic            buf_ready,
    input  logic            pic_top,
    input  logic            pic_frame,
    input  logic            pic_is_b,
    input  logic            low_delay,
    input  logic            ts_chk_en,
    input  logic            dec_done,
    output logic            dec_start_o,
    output logic            skip_o,
    output logic            discard_o,
    output logic [TAGW-1:0] pic_tag_o,
    output logic [2:0]      state_o,
    output logic [TW-1:0]   stc_o
);
    sched_st_e       state_q;
    run_mode_e       mode_q;
    logic [2:0]      pend_q;
    logic [1:0]      edges_q;
    logic            sync_q;
    logic [TW-1:0]   jf_q, jb_q;
    logic [TW-1:0]   head_ts;
    logic [TAGW-1:0] head_tag;
    logic            fifo_empty, ts_late, ts_early;
    logic            sync_edge, eval_st, last_edge, launch, cmd_apply, fifo_flush;
    logic            blocked, drop_late, wait_early, ff_skip;
    logic            go_start, go_skip, go_discard, go_hold, fifo_pop;

    picsync_stc #(.TW(TW), .DIV(STC_DIV)) u_stc (
        .clk(clk), .rst_n(rst_n), .tick(tick_27m), .load(stc_ld),
        .load_val(stc_ld_val), .stc(stc_o)
    );

    picsync_ts_fifo #(.TW(TW), .NW(TAGW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(ts_push),
        .push_ts(ts_val), .push_tag(ts_tag), .pop(fifo_pop),
        .head_ts(head_ts), .head_tag(head_tag), .empty(fifo_empty)
    );

    picsync_window #(.TW(TW)) u_win (
        .dts(head_ts), .stc(stc_o), .jit_fwd(jf_q), .jit_bwd(jb_q),
        .late(ts_late), .early(ts_early)
    );

    // Remember the previous sync level to find level changes.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= disp_sync;
    end

    // Hold the forward and backward tolerances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            jf_q <= TW'(JF_RST);
            jb_q <= TW'(JB_RST);
        end else if (tol_wr) begin
            if (tol_sel) jb_q <= tol_val;
            else         jf_q <= tol_val;
        end
    end

    // Launch, command and per-picture decision conditions in priority order.
    always_comb begin
        sync_edge  = disp_sync ^ sync_q;
        last_edge  = sync_edge && (edges_q <= 2'd1);
        launch     = ((state_q == ST_WAIT) && last_edge)
                   || ((state_q == ST_BUSY) && dec_done && last_edge)
                   || ((state_q == ST_OVR) && dec_done);
        cmd_apply  = launch || ((state_q == ST_HOLD) && sync_edge);
        fifo_flush = cmd_apply && (pend_q == CMD_RESET);
        eval_st    = (state_q == ST_CHECK) || (state_q == ST_HOLD);
        blocked    = (mode_q == RM_PAUSE) || (pic_top != disp_sync) || !buf_ready;
        drop_late  = ts_chk_en && !fifo_empty && ts_late && (low_delay || pic_is_b);
        wait_early = ts_chk_en && !fifo_empty && ts_early;
        ff_skip    = (mode_q == RM_FAST) && pic_is_b;
        go_discard = eval_st && !blocked && drop_late;
        go_hold    = eval_st && (blocked || (!drop_late && wait_early));
        go_skip    = eval_st && !blocked && !drop_late && !wait_early && ff_skip;
        go_start   = eval_st && !blocked && !drop_late && !wait_early && !ff_skip;
        fifo_pop   = go_start || go_skip || go_discard;
    end

    // Pending command latch, cleared once it has been applied.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= CMD_NONE;
        else if (cmd_wr)    pend_q <= cmd_code;
        else if (cmd_apply) pend_q <= CMD_NONE;
    end

    // Run mode update from applied commands and single-step completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= RM_PLAY;
        end else if (cmd_apply) begin
            case (pend_q)
                CMD_PAUSE:          mode_q <= RM_PAUSE;
                CMD_STEP:           mode_q <= RM_STEP;
                CMD_FAST:           mode_q <= RM_FAST;
                CMD_NONE:           mode_q <= mode_q;
                CMD_RESET, CMD_PLAY: mode_q <= RM_PLAY;
                default:            mode_q <= RM_PLAY;
            endcase
        end else if (go_start && (mode_q == RM_STEP)) begin
            mode_q <= RM_PAUSE;
        end
    end

    // Scheduler state and remaining sync changes of the current duration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            edges_q <= 2'd0;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (launch)         state_q <= ST_CHECK;
                    else if (sync_edge) edges_q <= edges_q - 2'd1;
                end
                ST_CHECK, ST_HOLD: begin
                    if (go_start) begin
                        state_q <= ST_BUSY;
                        edges_q <= pic_frame ? 2'd2 : 2'd1;
                    end else if (go_skip || go_discard) begin
                        state_q <= ST_WAIT;
                        edges_q <= 2'd0;
                    end else begin
                        state_q <= ST_HOLD;
                    end
                end
                ST_BUSY: begin
                    if (launch) begin
                        state_q <= ST_CHECK;
                    end else if (dec_done) begin
                        state_q <= ST_WAIT;
                        if (sync_edge) edges_q <= edges_q - 2'd1;
                    end else if (last_edge) begin
                        state_q <= ST_OVR;
                    end else if (sync_edge) begin
                        edges_q <= edges_q - 2'd1;
                    end
                end
                ST_OVR: begin
                    if (launch) state_q <= ST_CHECK;
                end
                default: state_q <= ST_WAIT;
            endcase
        end
    end

    // Registered decision pulses and the tag of the consumed timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_start_o <= 1'b0;
            skip_o      <= 1'b0;
            discard_o   <= 1'b0;
            pic_tag_o   <= '0;
        end else begin
            dec_start_o <= go_start;
            skip_o      <= go_skip;
            discard_o   <= go_discard;
            if (fifo_pop) pic_tag_o <= fifo_empty ? '0 : head_tag;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/picsync_sched_chk.sv
// Property checker for the picture decode scheduler, bound to every instance.
// Assumes past_ok gates any $past use to cycles after reset release.
module picsync_sched_chk
    import picsync_pkg::*;
#(
    parameter int TW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_27m,
    input logic          stc_ld,
    input logic [TW-1:0] stc_ld_val,
    input logic [TW-1:0] stc_o,
    input logic          dec_done,
    input logic          dec_start_o,
    input logic          skip_o,
    input logic          discard_o,
    input logic [2:0]    state_o
);
    logic past_ok;

    // Mark cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R12
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_start_o, skip_o, discard_o}));

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_start_o |=> !dec_start_o);

    // R2
    stc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stc_ld |=> (stc_o == $past(stc_ld_val)));

    // R2
    stc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stc_ld && !tick_27m) |=> $stable(stc_o));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && dec_start_o) |->
            ((state_o == ST_BUSY) && (($past(state_o) == ST_CHECK) || ($past(state_o) == ST_HOLD))));

    // R10
    ovr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (state_o == ST_OVR) && ($past(state_o) != ST_OVR)) |-> ($past(state_o) == ST_BUSY));

    // R10
    ovr_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($past(state_o) == ST_OVR) && (state_o != ST_OVR)) |-> $past(dec_done));
endmodule

bind picsync_sched picsync_sched_chk #(.TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_27m(tick_27m), .stc_ld(stc_ld),
    .stc_ld_val(stc_ld_val), .stc_o(stc_o), .dec_done(dec_done),
    .dec_start_o(dec_start_o), .skip_o(skip_o), .discard_o(discard_o),
    .state_o(state_o)
);

// File: tb/picsync_sched_tb.sv
`timescale 1ns/1ps
module picsync_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick_27m, stc_ld, tol_wr, tol_sel, ts_push, cmd_wr;
    logic [19:0] stc_ld_val, tol_val, ts_val;
    logic [7:0]  ts_tag;
    logic [2:0]  cmd_code;
    logic        disp_sync, buf_ready, pic_top, pic_frame, pic_is_b, low_delay, ts_chk_en, dec_done;
    logic        dec_start_o, skip_o, discard_o;
    logic [7:0]  pic_tag_o;
    logic [2:0]  state_o;
    logic [19:0] stc_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // Observation results
    logic       got_s, got_k, got_d;
    logic [7:0] got_tag;
    int         n_pulse;

    localparam logic [19:0] BASE = 20'h12345;
    // {low_delay, pic_is_b, offset[19:0], outcome[1:0]}; outcome 0 start, 1 discard, 2 hold
    localparam int NVEC = 9;
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 20'h00000, 2'd0},
        {1'b0, 1'b0, 20'h00E0F, 2'd0},
        {1'b0, 1'b0, 20'h00E10, 2'd2},
        {1'b0, 1'b1, 20'hFFABB, 2'd0},
        {1'b0, 1'b1, 20'hFFABA, 2'd1},
        {1'b0, 1'b0, 20'hFFABA, 2'd0},
        {1'b1, 1'b0, 20'hFF830, 2'd1},
        {1'b0, 1'b0, 20'h40000, 2'd2},
        {1'b0, 1'b1, 20'h80001, 2'd1}
    };

    always #2.5 clk = ~clk;

    picsync_sched u_dut (
        .clk(clk), .rst_n(rst_n), .tick_27m(tick_27m), .stc_ld(stc_ld),
        .stc_ld_val(stc_ld_val), .tol_wr(tol_wr), .tol_sel(tol_sel), .tol_val(tol_val),
        .ts_push(ts_push), .ts_val(ts_val), .ts_tag(ts_tag), .cmd_wr(cmd_wr),
        .cmd_code(cmd_code), .disp_sync(disp_sync), .buf_ready(buf_ready),
        .pic_top(pic_top), .pic_frame(pic_frame), .pic_is_b(pic_is_b),
        .low_delay(low_delay), .ts_chk_en(ts_chk_en), .dec_done(dec_done),
        .dec_start_o(dec_start_o), .skip_o(skip_o), .discard_o(discard_o),
        .pic_tag_o(pic_tag_o), .state_o(state_o), .stc_o(stc_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic toggle_sync();
        pic_top   = ~disp_sync;
        disp_sync = ~disp_sync;
    endtask

    task automatic observe(input int n);
        got_s = 0; got_k = 0; got_d = 0; got_tag = 8'h00; n_pulse = 0;
        repeat (n) begin
            @(negedge clk);
            if (dec_start_o || skip_o || discard_o) begin
                got_tag = pic_tag_o;
                n_pulse = n_pulse + int'(dec_start_o) + int'(skip_o) + int'(discard_o);
            end
            if (dec_start_o) got_s = 1;
            if (skip_o)      got_k = 1;
            if (discard_o)   got_d = 1;
        end
    endtask

    task automatic done_pulse();
        dec_done = 1; cyc(1); dec_done = 0; cyc(1);
    endtask

    task automatic load_stc(input logic [19:0] v);
        stc_ld_val = v; stc_ld = 1; cyc(1); stc_ld = 0;
    endtask

    task automatic push_ts(input logic [19:0] v, input logic [7:0] t);
        ts_val = v; ts_tag = t; ts_push = 1; cyc(1); ts_push = 0;
    endtask

    task automatic write_cmd(input logic [2:0] c);
        cmd_code = c; cmd_wr = 1; cyc(1); cmd_wr = 0;
    endtask

    task automatic write_tol(input logic sel, input logic [19:0] v);
        tol_sel = sel; tol_val = v; tol_wr = 1; cyc(1); tol_wr = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 0; tick_27m = 0; stc_ld = 0; stc_ld_val = 0; tol_wr = 0; tol_sel = 0; tol_val = 0;
        ts_push = 0; ts_val = 0; ts_tag = 0; cmd_wr = 0; cmd_code = 3'd7;
        disp_sync = 0; buf_ready = 1; pic_top = 0; pic_frame = 0; pic_is_b = 0;
        low_delay = 0; ts_chk_en = 1; dec_done = 0;
        cyc(3);
        rst_n = 1;
        cyc(1);
        // R1 reset state
        check("R1 state", int'(state_o), 0);
        check("R1 pulses", int'({dec_start_o, skip_o, discard_o}), 0);
        check("R1 stc", int'(stc_o), 0);

        // Vector table: window edges, late/early, signed distance
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] off;
            logic [1:0]  exp_o;
            int          outc;
            string       tag_r;
            off   = VEC[i][21:2];
            exp_o = VEC[i][1:0];
            low_delay = VEC[i][23];
            pic_is_b  = VEC[i][22];
            tag_r = (exp_o == 2'd2) ? "R5" : ((exp_o == 2'd1) ? "R4" : "R3");
            load_stc(BASE);
            push_ts(BASE + off, 8'(i + 1));
            toggle_sync();
            observe(6);
            outc = got_s ? 0 : (got_d ? 1 : ((state_o == 3'd2) ? 2 : 3));
            check(tag_r, outc, int'(exp_o));
            if (exp_o != 2'd2) begin
                check("R12 one pulse", n_pulse, 1);
                check("R8 tag", int'(got_tag), i + 1);
            end
            if (exp_o == 2'd2) begin
                load_stc(BASE + off);
                observe(4);
                check("R5 release", int'(got_s), 1);
                check("R8 tag after hold", int'(got_tag), i + 1);
            end
            if (got_s) done_pulse();
            low_delay = 0; pic_is_b = 0;
        end

        // R2 prescale by 300 and wraparound
        stc_ld_val = 20'hFFFFF; stc_ld = 1; tick_27m = 1; cyc(1); stc_ld = 0;
        check("R2 load", int'(stc_o), 20'hFFFFF);
        cyc(299);
        check("R2 no step before 300", int'(stc_o), 20'hFFFFF);
        cyc(1);
        check("R2 step and wrap", int'(stc_o), 0);
        tick_27m = 0;

        // R3 window across counter wrap
        load_stc(20'hFFFF0);
        push_ts(20'h00010, 8'h31);
        toggle_sync(); observe(6);
        check("R3 wrap in window", int'(got_s), 1);
        if (got_s) done_pulse();

        // R6 empty FIFO, then checking disabled with an early timestamp
        toggle_sync(); observe(6);
        check("R6 empty fifo start", int'(got_s), 1);
        check("R6 empty tag", int'(got_tag), 0);
        if (got_s) done_pulse();
        ts_chk_en = 0;
        load_stc(BASE);
        push_ts(BASE + 20'h40000, 8'h32);
        toggle_sync(); observe(6);
        check("R6 check disabled", int'(got_s), 1);
        if (got_s) done_pulse();
        ts_chk_en = 1;

        // R7 underflow hold
        buf_ready = 0;
        toggle_sync(); observe(6);
        check("R7 underflow hold", int'(state_o), 2);
        check("R7 no start", int'(got_s), 0);
        buf_ready = 1; observe(4);
        check("R7 underflow release", int'(got_s), 1);
        if (got_s) done_pulse();

        // R7 parity hold until the sync level matches
        pic_top = disp_sync; disp_sync = ~disp_sync; observe(6);
        check("R7 parity hold", int'(state_o), 2);
        disp_sync = ~disp_sync; observe(6);
        check("R7 parity release", int'(got_s), 1);
        if (got_s) done_pulse();

        // R9 frame picture spans two sync changes
        pic_frame = 1;
        toggle_sync(); observe(6);
        check("R9 frame start", int'(got_s), 1);
        pic_frame = 0;
        done_pulse();
        toggle_sync(); observe(6);
        check("R9 first change ignored", int'(got_s), 0);
        check("R9 waiting", int'(state_o), 0);
        toggle_sync(); observe(6);
        check("R9 second change launches", int'(got_s), 1);
        if (got_s) done_pulse();

        // R10 overrun then immediate relaunch on done
        toggle_sync(); observe(6);
        check("R10 start", int'(got_s), 1);
        toggle_sync(); observe(4);
        check("R10 overrun state", int'(state_o), 4);
        check("R10 no start without done", int'(got_s), 0);
        pic_top = disp_sync;
        dec_done = 1; cyc(1); dec_done = 0;
        observe(4);
        check("R10 relaunch on done", int'(got_s), 1);
        if (got_s) done_pulse();

        // R11 pause and resume
        write_cmd(3'd5);
        toggle_sync(); observe(6);
        check("R11 pause hold", int'(state_o), 2);
        check("R11 pause no start", int'(got_s), 0);
        write_cmd(3'd1);
        toggle_sync(); observe(6);
        check("R11 resume", int'(got_s), 1);
        if (got_s) done_pulse();

        // R11 single step
        write_cmd(3'd4);
        toggle_sync(); observe(6);
        check("R11 step decodes one", int'(got_s), 1);
        if (got_s) done_pulse();
        toggle_sync(); observe(6);
        check("R11 step then paused", int'(state_o), 2);
        write_cmd(3'd1);
        toggle_sync(); observe(6);
        check("R11 play after step", int'(got_s), 1);
        if (got_s) done_pulse();

        // R11 fast forward skips B pictures
        write_cmd(3'd6);
        pic_is_b = 1;
        toggle_sync(); observe(6);
        check("R11 fast skip pulse", int'(got_k), 1);
        check("R11 fast back to wait", int'(state_o), 0);
        pic_is_b = 0;
        toggle_sync(); observe(6);
        check("R11 fast decodes non-B", int'(got_s), 1);
        if (got_s) done_pulse();

        // R11 reset command flushes queued early timestamps
        load_stc(BASE);
        push_ts(BASE + 20'h40000, 8'h41);
        push_ts(BASE + 20'h40000, 8'h42);
        write_cmd(3'd0);
        toggle_sync(); observe(6);
        check("R11 flush start", int'(got_s), 1);
        check("R11 flush tag", int'(got_tag), 0);
        if (got_s) done_pulse();

        // R8 depth 4, fifth push dropped, order kept
        for (int k = 0; k < 5; k++) push_ts(BASE, 8'(8'h50 + k));
        for (int k = 0; k < 5; k++) begin
            toggle_sync(); observe(6);
            check("R8 order", int'(got_tag), (k < 4) ? (8'h50 + k) : 0);
            if (got_s) done_pulse();
        end

        // R3 tolerance writes
        write_tol(1'b0, 20'd10);
        load_stc(BASE);
        push_ts(BASE + 20'd10, 8'h61);
        toggle_sync(); observe(6);
        check("R3 new forward bound holds", int'(state_o), 2);
        load_stc(BASE + 20'd5);
        observe(4);
        check("R3 inside new bound", int'(got_s), 1);
        if (got_s) done_pulse();
        write_tol(1'b1, 20'hFFFFB);
        pic_is_b = 1;
        push_ts(BASE, 8'h62);
        toggle_sync(); observe(6);
        check("R3 new backward bound discards", int'(got_d), 1);
        pic_is_b = 0;

        finish_run();
    end
endmodule